// File: doc/BRIEF.md
# Serial RGB Panel Timing Generator

This block drives a small colour panel over an 8-bit data bus. It produces the line sync, frame sync, data-enable, a bus clock and a byte strobe. Each 24-bit pixel crosses the bus as three bytes: red first, then green, then blue. The active area defaults to 320 pixels by 240 lines and is set by parameters. Sync widths and margins come from configuration inputs. Horizontal quantities are counted in byte periods and vertical quantities in lines. Suggested settings are a line sync of 1, a left margin of 140 and a right margin of 273 byte periods, with a frame sync of 1 line, an upper margin of 20 lines and a lower margin of 2 lines.

Pixels come from an upstream source through a ready/valid handshake. Ready is raised for one clock when the red byte of a new pixel is due. If the source is not valid at that moment, the block sends a black pixel and keeps the line timing unchanged. It does not consume a pixel and it sets a sticky underrun flag. Four configuration bits invert line sync, frame sync, data-enable and the bus clock. A fifth bit complements the data bytes.

The byte period is two clocks. The first clock launches the byte and the second is the sampling half. Two segment-timer state machines step through the states SEG_SYNC → SEG_BACK → SEG_ACT → SEG_FRONT → SEG_SYNC. The horizontal timer advances once per byte period. The vertical timer advances when the horizontal timer leaves its SEG_FRONT state. A colour state machine cycles COL_RED → COL_GREEN → COL_BLUE → COL_RED, advancing once per active byte.

Top module: `rgb_serial_tx`

## Requirements
- R1: A line lasts hsync_len + left + 3·ACT_W + right byte periods, in this order: sync, left margin, active bytes, right margin. The line sync is asserted exactly during the sync byte periods.
- R2: A frame lasts vsync_len + upper + ACT_H + lower lines, in this order: sync lines, upper margin, active lines, lower margin. The frame sync is asserted for every byte of the sync lines.
- R3: Within a pixel, the bus carries pixel bits 23:16 (red), then bits 15:8 (green), then bits 7:0 (blue), on three consecutive byte periods.
- R4: Data-enable is asserted only during the active bytes of active lines. The data bus is zero at all other times.
- R5: With hs_pol_i = 1 the line sync is active low; with 0 it is active high.
- R6: With vs_pol_i = 1 the frame sync is active low; with 0 it is active high.
- R7: With de_pol_i = 1 data-enable is active low; with 0 it is active high.
- R8: Each byte period is two clocks. The byte strobe is high during the first clock only. During that first clock the bus clock equals pclk_pol_i, so 0 gives a rising sampling edge and 1 a falling edge. The bus clock takes the opposite level in the second clock.
- R9: With inv_i = 1 every active byte is complemented. The bus stays zero outside active bytes.
- R10: Ready is high for single clocks, once at the red byte of each active pixel. A pixel is consumed only when ready and valid are both high.
- R11: When valid is low at a ready, the pixel is sent as three zero bytes (before R9 inversion) and no pixel is consumed. The underrun flag rises with that pixel's red byte and stays set until reset.
- R12: During and right after reset, every sync and enable output sits at its inactive level, the data bus is zero, and strobe, ready and underrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_len_i | input | HCW | Line sync width in byte periods (at least 1) |
| left_i | input | HCW | Byte periods between line sync and active bytes (at least 1) |
| right_i | input | HCW | Byte periods after active bytes (at least 1) |
| vsync_len_i | input | VCW | Frame sync width in lines (at least 1) |
| upper_i | input | VCW | Lines between frame sync and active lines (at least 1) |
| lower_i | input | VCW | Lines after active lines (at least 1) |
| hs_pol_i | input | 1 | 1 = line sync active low |
| vs_pol_i | input | 1 | 1 = frame sync active low |
| de_pol_i | input | 1 | 1 = data-enable active low |
| pclk_pol_i | input | 1 | 1 = falling sampling edge |
| inv_i | input | 1 | 1 = complement active data bytes |
| pix_data_i | input | 3·BW | Pixel, red in top byte |
| pix_valid_i | input | 1 | Source has a pixel |
| pix_ready_o | output | 1 | Block takes a pixel this clock if valid |
| lcd_dclk_o | output | 1 | Bus clock |
| lcd_byte_en_o | output | 1 | High in the first clock of each byte period |
| lcd_hsync_o | output | 1 | Line sync |
| lcd_vsync_o | output | 1 | Frame sync |
| lcd_de_o | output | 1 | Data-enable |
| lcd_data_o | output | BW | Data byte |
| underrun_o | output | 1 | Sticky: a pixel was needed and none was valid |

## Verification
The hardest case to reach from the ports is one refused pixel in the middle of an active line, followed by a clean recovery. The next pixel must arrive in its proper slot, with no lost or repeated byte, while the underrun flag stays set. The stimulus makes the source's valid depend on how many ready pulses it has already seen. Exactly the third request is refused, while the model keeps its own count of consumed pixels. A separate directed run holds valid low and measures the byte period in which the flag first rises. That period must be the first red byte of the first active line.

// File: rtl/rgb_serial_pkg.sv
package rgb_serial_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC,
        SEG_BACK,
        SEG_ACT,
        SEG_FRONT
    } seg_e;

    typedef enum logic [1:0] {
        COL_RED,
        COL_GREEN,
        COL_BLUE
    } col_e;

    localparam int BYTES_PER_PIX = 3;

    // suggested timing for the 320x240 panel
    localparam int DEF_HSYNC = 1;
    localparam int DEF_LEFT  = 140;
    localparam int DEF_RIGHT = 273;
    localparam int DEF_VSYNC = 1;
    localparam int DEF_UPPER = 20;
    localparam int DEF_LOWER = 2;

endpackage

// File: rtl/rgb_seg_timer.sv
// Four-segment period timer: sync, back margin, active, front margin.
module rgb_seg_timer
    import rgb_serial_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    output seg_e          seg_o,
    output logic          wrap_o
);

    seg_e          seg_q, seg_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] seg_len;
    logic          seg_last;

    always_comb begin
        unique case (seg_q)
            SEG_SYNC:  seg_len = len_sync;
            SEG_BACK:  seg_len = len_back;
            SEG_ACT:   seg_len = len_act;
            SEG_FRONT: seg_len = len_front;
            default:   seg_len = len_sync;
        endcase
    end

    assign seg_last = (cnt_q == seg_len - 1'b1);

    // next-state logic
    always_comb begin
        seg_d = seg_q;
        cnt_d = cnt_q;
        if (adv) begin
            if (seg_last) begin
                cnt_d = '0;
                unique case (seg_q)
                    SEG_SYNC:  seg_d = SEG_BACK;
                    SEG_BACK:  seg_d = SEG_ACT;
                    SEG_ACT:   seg_d = SEG_FRONT;
                    SEG_FRONT: seg_d = SEG_SYNC;
                    default:   seg_d = SEG_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
        end
    end

    assign seg_o  = seg_q;
    assign wrap_o = seg_last && (seg_q == SEG_FRONT);

endmodule

// File: rtl/rgb_byte_fmt.sv
// Splits each pixel into red, green, blue bytes and handles the handshake.
module rgb_byte_fmt
    import rgb_serial_pkg::*;
#(
    parameter int BW = 8,
    localparam int PW = BYTES_PER_PIX * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          active,
    input  logic [PW-1:0] pix_data_i,
    input  logic          pix_valid_i,
    output logic          pix_ready_o,
    output logic [BW-1:0] byte_o,
    output logic          underrun_o
);

    col_e            col_q, col_d;
    logic [BW-1:0]   byte_q, byte_d;
    logic [2*BW-1:0] gb_q, gb_d;
    logic            urun_q, urun_d;

    assign pix_ready_o = tick && active && (col_q == COL_RED);

    // colour state and transitions
    always_comb begin
        col_d = col_q;
        if (tick && active) begin
            unique case (col_q)
                COL_RED:   col_d = COL_GREEN;
                COL_GREEN: col_d = COL_BLUE;
                COL_BLUE:  col_d = COL_RED;
                default:   col_d = COL_RED;
            endcase
        end
    end

    // byte outputs
    always_comb begin
        byte_d = byte_q;
        gb_d   = gb_q;
        urun_d = urun_q;
        if (tick) begin
            if (!active) begin
                byte_d = '0;
            end else begin
                unique case (col_q)
                    COL_RED: begin
                        if (pix_valid_i) begin
                            byte_d = pix_data_i[PW-1 -: BW];
                            gb_d   = pix_data_i[2*BW-1:0];
                        end else begin
                            byte_d = '0;
                            gb_d   = '0;
                            urun_d = 1'b1;
                        end
                    end
                    COL_GREEN: byte_d = gb_q[2*BW-1 -: BW];
                    COL_BLUE:  byte_d = gb_q[BW-1:0];
                    default:   byte_d = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= COL_RED;
            byte_q <= '0;
            gb_q   <= '0;
            urun_q <= 1'b0;
        end else begin
            col_q  <= col_d;
            byte_q <= byte_d;
            gb_q   <= gb_d;
            urun_q <= urun_d;
        end
    end

    assign byte_o     = byte_q;
    assign underrun_o = urun_q;

endmodule

// File: rtl/rgb_serial_tx.sv
// Serial RGB panel timing generator, top level.
module rgb_serial_tx
    import rgb_serial_pkg::*;
#(
    parameter int ACT_W = 320,
    parameter int ACT_H = 240,
    parameter int HCW   = 12,
    parameter int VCW   = 10,
    parameter int BW    = 8,
    localparam int PW   = BYTES_PER_PIX * BW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HCW-1:0] hsync_len_i,
    input  logic [HCW-1:0] left_i,
    input  logic [HCW-1:0] right_i,
    input  logic [VCW-1:0] vsync_len_i,
    input  logic [VCW-1:0] upper_i,
    input  logic [VCW-1:0] lower_i,
    input  logic           hs_pol_i,
    input  logic           vs_pol_i,
    input  logic           de_pol_i,
    input  logic           pclk_pol_i,
    input  logic           inv_i,
    input  logic [PW-1:0]  pix_data_i,
    input  logic           pix_valid_i,
    output logic           pix_ready_o,
    output logic           lcd_dclk_o,
    output logic           lcd_byte_en_o,
    output logic           lcd_hsync_o,
    output logic           lcd_vsync_o,
    output logic           lcd_de_o,
    output logic [BW-1:0]  lcd_data_o,
    output logic           underrun_o
);

    localparam logic [HCW-1:0] H_ACT_LEN = HCW'(ACT_W * BYTES_PER_PIX);
    localparam logic [VCW-1:0] V_ACT_LEN = VCW'(ACT_H);

    logic          ph_q;
    logic          tick;
    seg_e          hseg, vseg;
    logic          hwrap, vwrap;
    logic          active;
    logic          hs_q, vs_q, de_q, ben_q;
    logic [BW-1:0] fmt_byte;

    // byte period: launch half (ph_q=0), sample half (ph_q=1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end
    assign tick = ph_q;

    rgb_seg_timer #(.CW(HCW)) i_htimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (tick),
        .len_sync  (hsync_len_i),
        .len_back  (left_i),
        .len_act   (H_ACT_LEN),
        .len_front (right_i),
        .seg_o     (hseg),
        .wrap_o    (hwrap)
    );

    rgb_seg_timer #(.CW(VCW)) i_vtimer (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (tick && hwrap),
        .len_sync  (vsync_len_i),
        .len_back  (upper_i),
        .len_act   (V_ACT_LEN),
        .len_front (lower_i),
        .seg_o     (vseg),
        .wrap_o    (vwrap)
    );

    assign active = (hseg == SEG_ACT) && (vseg == SEG_ACT);

    rgb_byte_fmt #(.BW(BW)) i_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .active      (active),
        .pix_data_i  (pix_data_i),
        .pix_valid_i (pix_valid_i),
        .pix_ready_o (pix_ready_o),
        .byte_o      (fmt_byte),
        .underrun_o  (underrun_o)
    );

    // output stage, aligned with the formatter byte register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            vs_q  <= 1'b0;
            de_q  <= 1'b0;
            ben_q <= 1'b0;
        end else begin
            ben_q <= tick;
            if (tick) begin
                hs_q <= (hseg == SEG_SYNC);
                vs_q <= (vseg == SEG_SYNC);
                de_q <= active;
            end
        end
    end

    assign lcd_byte_en_o = ben_q;
    assign lcd_dclk_o    = ph_q ^ pclk_pol_i;
    assign lcd_hsync_o   = hs_q ^ hs_pol_i;
    assign lcd_vsync_o   = vs_q ^ vs_pol_i;
    assign lcd_de_o      = de_q ^ de_pol_i;
    assign lcd_data_o    = de_q ? (fmt_byte ^ {BW{inv_i}}) : '0;

    logic unused_ok;
    assign unused_ok = vwrap;

endmodule

// File: rtl/rgb_serial_chk.sv
module rgb_serial_chk #(
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_valid_i,
    input logic          pix_ready_o,
    input logic          lcd_dclk_o,
    input logic          lcd_byte_en_o,
    input logic          lcd_hsync_o,
    input logic          lcd_vsync_o,
    input logic          lcd_de_o,
    input logic [BW-1:0] lcd_data_o,
    input logic          underrun_o,
    input logic          hs_pol_i,
    input logic          vs_pol_i,
    input logic          de_pol_i,
    input logic          pclk_pol_i
);

    p_de_no_hsync_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_de_o != de_pol_i) |-> (lcd_hsync_o == hs_pol_i));

    p_de_no_vsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_de_o != de_pol_i) |-> (lcd_vsync_o == vs_pol_i));

    p_idle_bus_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_de_o == de_pol_i) |-> (lcd_data_o == '0));

    p_dclk_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_byte_en_o |-> (lcd_dclk_o == pclk_pol_i));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_byte_en_o |=> !lcd_byte_en_o);

    p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready_o |=> !pix_ready_o);

    p_underrun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready_o && !pix_valid_i) |=> underrun_o);

    p_underrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> underrun_o);

endmodule

bind rgb_serial_tx rgb_serial_chk #(.BW(BW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_valid_i   (pix_valid_i),
    .pix_ready_o   (pix_ready_o),
    .lcd_dclk_o    (lcd_dclk_o),
    .lcd_byte_en_o (lcd_byte_en_o),
    .lcd_hsync_o   (lcd_hsync_o),
    .lcd_vsync_o   (lcd_vsync_o),
    .lcd_de_o      (lcd_de_o),
    .lcd_data_o    (lcd_data_o),
    .underrun_o    (underrun_o),
    .hs_pol_i      (hs_pol_i),
    .vs_pol_i      (vs_pol_i),
    .de_pol_i      (de_pol_i),
    .pclk_pol_i    (pclk_pol_i)
);

// File: tb/test_rgb_serial_tx.sv
`timescale 1ns/1ps
module test_rgb_serial_tx;
    import rgb_serial_pkg::*;

    localparam int W   = 4;
    localparam int H   = 3;
    localparam int HCW = 12;
    localparam int VCW = 10;

    typedef struct packed {
        logic [11:0] hs, hl, hr, vs, vu, vl;
        logic hp, vp, dp, cp, inv;
        logic [1:0] mode; // 0 always valid, 1 never valid, 2 third request refused
    } row_t;

    localparam int NROW = 6;
    localparam row_t TBL [NROW] = '{
        '{12'd1, 12'd3, 12'd2, 12'd1, 12'd2, 12'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{12'd2, 12'd1, 12'd1, 12'd2, 12'd1, 12'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0},
        '{12'd1, 12'd2, 12'd3, 12'd1, 12'd1, 12'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0},
        '{12'd1, 12'd1, 12'd1, 12'd1, 12'd1, 12'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
        '{12'd1, 12'd2, 12'd2, 12'd1, 12'd1, 12'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
        '{12'(DEF_HSYNC), 12'(DEF_LEFT), 12'(DEF_RIGHT), 12'd1, 12'd2, 12'd2,
          1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HCW-1:0] hs_len = 1, hl_len = 1, hr_len = 1;
    logic [VCW-1:0] vs_len = 1, vu_len = 1, vl_len = 1;
    logic hp = 0, vp = 0, dp = 0, cp = 0, inv = 0;
    logic [1:0] mode = 0;
    logic [23:0] pix_data = 0;
    logic pix_valid = 0;
    logic pix_ready, dclk, ben, hsync, vsync, de, urun;
    logic [7:0] data;

    int tests = 0;
    int fails = 0;
    int seq = 0;
    int attempts = 0;

    always #2.5 clk = ~clk;

    rgb_serial_tx #(.ACT_W(W), .ACT_H(H), .HCW(HCW), .VCW(VCW), .BW(8)) i_rgb_serial_tx (
        .clk(clk), .rst_n(rst_n),
        .hsync_len_i(hs_len), .left_i(hl_len), .right_i(hr_len),
        .vsync_len_i(vs_len), .upper_i(vu_len), .lower_i(vl_len),
        .hs_pol_i(hp), .vs_pol_i(vp), .de_pol_i(dp), .pclk_pol_i(cp), .inv_i(inv),
        .pix_data_i(pix_data), .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
        .lcd_dclk_o(dclk), .lcd_byte_en_o(ben), .lcd_hsync_o(hsync),
        .lcd_vsync_o(vsync), .lcd_de_o(de), .lcd_data_o(data), .underrun_o(urun)
    );

    function automatic logic [23:0] pix(input int n);
        return {8'(n * 3 + 1), 8'(n * 5 + 2), 8'(n * 7 + 3)};
    endfunction

    function automatic logic valid_fn(input logic [1:0] m, input int a);
        if (m == 2'd1) return 1'b0;
        if (m == 2'd2) return (a != 2);
        return 1'b1;
    endfunction

    // upstream pixel source
    initial begin
        forever begin
            logic take, att;
            @(negedge clk);
            take = pix_ready && pix_valid;
            att  = pix_ready;
            @(posedge clk);
            #1;
            if (!rst_n) begin
                seq = 0;
                attempts = 0;
            end else begin
                if (take) seq++;
                if (att) attempts++;
            end
            pix_data  = pix(seq);
            pix_valid = valid_fn(mode, attempts);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply_reset(input row_t r);
        @(negedge clk);
        rst_n = 1'b0;
        hs_len = r.hs; hl_len = r.hl; hr_len = r.hr;
        vs_len = VCW'(r.vs); vu_len = VCW'(r.vu); vl_len = VCW'(r.vl);
        hp = r.hp; vp = r.vp; dp = r.dp; cp = r.cp; inv = r.inv; mode = r.mode;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(hsync == hp && vsync == vp && de == dp, "R12 sync/de idle",
            {hsync, vsync, de}, {hp, vp, dp});
        chk(data == 8'h00 && !urun && !pix_ready && !ben, "R12 data/flags idle",
            {data, urun, pix_ready, ben}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_byte();
        do @(negedge clk); while (!ben);
    endtask

    task automatic run_row(input row_t r);
        int L, F, nbytes, cons, att, vact0, hact0;
        logic [23:0] cur;
        bit miss_seen;
        L = int'(r.hs) + int'(r.hl) + 3 * W + int'(r.hr);
        F = int'(r.vs) + int'(r.vu) + H + int'(r.vl);
        hact0 = int'(r.hs) + int'(r.hl);
        vact0 = int'(r.vs) + int'(r.vu);
        nbytes = L * F + 2 * L;
        cons = 0; att = 0; cur = 0; miss_seen = 0;
        apply_reset(r);
        for (int k = 0; k < nbytes; k++) begin
            int x, ln, sub;
            bit eh, ev, ea;
            logic [7:0] eb;
            wait_byte();
            x  = k % L;
            ln = (k / L) % F;
            eh = (x < int'(r.hs));
            ev = (ln < int'(r.vs));
            ea = (ln >= vact0) && (ln < vact0 + H) && (x >= hact0) && (x < hact0 + 3 * W);
            eb = 8'h00;
            if (ea) begin
                sub = (x - hact0) % 3;
                if (sub == 0) begin
                    if (valid_fn(r.mode, att)) begin
                        cur = pix(cons);
                        cons++;
                    end else begin
                        cur = 24'h0;
                        miss_seen = 1;
                    end
                    att++;
                end
                eb = (sub == 0) ? cur[23:16] : (sub == 1) ? cur[15:8] : cur[7:0];
                if (r.inv) eb = ~eb;
            end
            chk(hsync == (eh ^ r.hp), "R1/R5 line sync", hsync, eh ^ r.hp);
            chk(vsync == (ev ^ r.vp), "R2/R6 frame sync", vsync, ev ^ r.vp);
            chk(de == (ea ^ r.dp), "R4/R7 data enable", de, ea ^ r.dp);
            chk(data == eb, "R3/R9/R11 data byte", data, eb);
            chk(dclk == r.cp, "R8 bus clock launch half", dclk, r.cp);
            chk(urun == miss_seen, "R11 underrun flag", urun, miss_seen);
        end
        @(negedge clk);
        chk(dclk == !r.cp && !ben, "R8 bus clock sample half", {dclk, ben}, {!r.cp, 1'b0});
        chk(seq == cons, "R10 pixels consumed", seq, cons);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NROW; i++) run_row(TBL[i]);

        // directed: first underrun appears exactly at the first red byte
        begin
            row_t r;
            int k, L, exp_k;
            r = TBL[0];
            r.mode = 2'd1;
            L = int'(r.hs) + int'(r.hl) + 3 * W + int'(r.hr);
            exp_k = L * (int'(r.vs) + int'(r.vu)) + int'(r.hs) + int'(r.hl);
            apply_reset(r);
            k = 0;
            wait_byte();
            while (!urun && k < 1000) begin
                k++;
                wait_byte();
            end
            chk(k == exp_k, "R11 underrun first slot", k, exp_k);
            chk(seq == 0, "R10 nothing consumed without valid", seq, 0);
        end

        // directed: reset clears sticky underrun
        apply_reset(TBL[0]);
        chk(!urun, "R12 underrun cleared by reset", urun, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule